// File: doc/BRIEF.md
# Queued Word-Copy DMA Engine

This block moves 32-bit words from a source region to a destination region of a memory, driven by commands that software builds in a small register file. Software writes a source address, a destination address and a source length, then writes the destination length; that last write commits all four values as one command into a four-entry queue. Commands run strictly in arrival order.

The engine works through a command in steps. Each step moves up to 256 words (1024 bytes). It reads words over a valid/ready memory port and hands them to a data sink output. In loopback mode it also writes each word back to the destination. A command retires when both of its remaining lengths are zero, which raises the done flags. A step that could move nothing while some length remains discards the command with an error flag. Flags are write-one-to-clear, and a mask register selects which flags drive the level interrupt.

Top module: `dmaq_top`

## Requirements
- R1: A write to DST_LEN (offset 0x0C) pushes a command made from SRC_ADDR (0x00), DST_ADDR (0x04), SRC_LEN (0x08) and the DST_LEN value being written. Both addresses have bits 1:0 forced to zero, and every memory request address has bits 1:0 equal to zero.
- R2: Length registers count 32-bit words. Only bits 26:0 are stored, and bits 31:27 read as zero.
- R3: A step moves min(256, remaining source words) words. In loopback the step is further limited by the remaining destination words, and both residuals shrink by the step size.
- R4: With loopback off, the engine issues only read requests, at consecutive word addresses from the source. Each read word appears on `sink_data` with `sink_valid` high.
- R5: With loopback on (MISC bit 4), each word read is written to the next consecutive destination word before the next read. The sink stays idle.
- R6: When both residual lengths are zero, the command is removed from the queue and INT_STS bits 13 and 12 are set. A command whose lengths are both zero retires with no memory access.
- R7: If a step would move zero words while a residual is non-zero, the command is removed and INT_STS bit 15 is set instead of bits 13 and 12.
- R8: The queue holds four commands, including the one in progress, and serves them in order. A push while it is full drops the command and sets INT_STS bit 14.
- R9: STATUS (0x1C, read-only) shows queue-full in bit 31, queue-empty in bit 30 and the queue count in bits 2:0.
- R10: `irq` is high when any bit of INT_STS (0x14) is set whose bit in INT_MASK (0x18) is zero. Writing a one to an INT_STS bit clears it.
- R11: CFG (0x10) has only bits 11:4 writable. MISC (0x20) has only bit 4 writable, and that bit is the loopback enable.
- R12: After reset, CFG reads 0x50B, INT_MASK reads 0xFFFFFFFF, INT_STS, MISC and the length registers read 0, STATUS reads 0x40000000, and `irq` is low.
- R13: While a memory request is held without `mem_req_ready`, the request stays valid and its address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid in the cycle a read is accepted |
| sink_valid | output | 1 | A read word is delivered to the sink |
| sink_data | output | 32 | Word delivered to the sink |
| irq | output | 1 | Level interrupt |

## Verification
A wrong residual count or step size shows up at the memory port: the number of reads or writes for a command comes out wrong. It also shows in which flag retires the command, done or error. Both are visible as soon as the queue drains. A lost or reordered queue entry changes the sequence of read addresses when a stalled memory is released. A wrong flag or mask bit shows on `irq` one cycle after the flag's register changes. Stalling the memory with `mem_req_ready` low makes queue occupancy and overflow visible in STATUS and INT_STS before any command retires.

// File: rtl/dmaq_pkg.sv
// Shared constants and the queued command type for the DMA engine.
// Assumes a 32-bit register and memory data path.
package dmaq_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 27;   // stored width of a word-length register

    // Register byte offsets
    localparam logic [7:0] OFS_SRC_ADDR = 8'h00;
    localparam logic [7:0] OFS_DST_ADDR = 8'h04;
    localparam logic [7:0] OFS_SRC_LEN  = 8'h08;
    localparam logic [7:0] OFS_DST_LEN  = 8'h0C;
    localparam logic [7:0] OFS_CFG      = 8'h10;
    localparam logic [7:0] OFS_INT_STS  = 8'h14;
    localparam logic [7:0] OFS_INT_MASK = 8'h18;
    localparam logic [7:0] OFS_STATUS   = 8'h1C;
    localparam logic [7:0] OFS_MISC     = 8'h20;

    // Flag bit positions in the interrupt status register
    localparam int FLG_PART = 12;
    localparam int FLG_DONE = 13;
    localparam int FLG_OVF  = 14;
    localparam int FLG_ERR  = 15;
    localparam int MISC_LOOP = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] src_addr;
        logic [ADDR_W-1:0] dst_addr;
        logic [LEN_W-1:0]  src_words;
        logic [LEN_W-1:0]  dst_words;
    } dma_cmd_t;
endpackage

// File: rtl/dmaq_regs.sv
// Register file: command staging, configuration, flags, mask and interrupt.
// Assumes single-cycle register writes and a combinational read mux.
// A flag set by an event in the same cycle as a clearing write stays set.
module dmaq_regs
    import dmaq_pkg::*;
#(
    parameter int          QCNT_W    = 3,
    parameter logic [31:0] CFG_RESET = 32'h0000_050B,
    parameter logic [31:0] CFG_WMASK = 32'h0000_0FF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              push,
    output dma_cmd_t          push_cmd,
    input  logic              q_full,
    input  logic              q_empty,
    input  logic [QCNT_W-1:0] q_count,
    input  logic              ev_done,
    input  logic              ev_err,
    output logic              loop_en,
    output logic              irq
);
    localparam logic [31:0] FLG_IMPL = (32'h1 << FLG_PART) | (32'h1 << FLG_DONE)
                                     | (32'h1 << FLG_OVF)  | (32'h1 << FLG_ERR);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

    logic [ADDR_W-1:0] src_addr_q, dst_addr_q;
    logic [LEN_W-1:0]  src_len_q, dst_len_q;
    logic [31:0]       cfg_q, sts_q, mask_q, sts_set, sts_clr, stat_word;
    logic              loop_q;

    // Command push is the write to the destination length
    assign push     = reg_wen && (reg_addr == OFS_DST_LEN);
    assign push_cmd = '{src_addr:  src_addr_q & ALIGN_MASK,
                        dst_addr:  dst_addr_q & ALIGN_MASK,
                        src_words: src_len_q,
                        dst_words: reg_wdata[LEN_W-1:0]};
    assign loop_en  = loop_q;

    // Plain read/write registers
    always_ff @(posedge clk) begin : p_cfg_regs
        if (!rst_n) begin
            src_addr_q <= '0;
            dst_addr_q <= '0;
            src_len_q  <= '0;
            dst_len_q  <= '0;
            cfg_q      <= CFG_RESET;
            mask_q     <= '1;
            loop_q     <= 1'b0;
        end else if (reg_wen) begin
            case (reg_addr)
                OFS_SRC_ADDR: src_addr_q <= reg_wdata;
                OFS_DST_ADDR: dst_addr_q <= reg_wdata;
                OFS_SRC_LEN:  src_len_q  <= reg_wdata[LEN_W-1:0];
                OFS_DST_LEN:  dst_len_q  <= reg_wdata[LEN_W-1:0];
                OFS_CFG:      cfg_q      <= (cfg_q & ~CFG_WMASK) | (reg_wdata & CFG_WMASK);
                OFS_INT_MASK: mask_q     <= reg_wdata;
                OFS_MISC:     loop_q     <= reg_wdata[MISC_LOOP];
                default: ;
            endcase
        end
    end

    // Event set vector and write-one-to-clear vector
    always_comb begin : p_flag_vectors
        sts_set           = '0;
        sts_set[FLG_DONE] = ev_done;
        sts_set[FLG_PART] = ev_done;
        sts_set[FLG_ERR]  = ev_err;
        sts_set[FLG_OVF]  = push && q_full;
        sts_clr = (reg_wen && reg_addr == OFS_INT_STS) ? reg_wdata : '0;
    end

    // Sticky flags: events set, writes of one clear
    always_ff @(posedge clk) begin : p_flags
        if (!rst_n) sts_q <= '0;
        else        sts_q <= ((sts_q & ~sts_clr) | sts_set) & FLG_IMPL;
    end

    assign irq = |(sts_q & ~mask_q);

    // Read-only queue status word
    always_comb begin : p_status_word
        stat_word             = '0;
        stat_word[31]         = q_full;
        stat_word[30]         = q_empty;
        stat_word[QCNT_W-1:0] = q_count;
    end

    // Read multiplexer
    always_comb begin : p_read_mux
        case (reg_addr)
            OFS_SRC_ADDR: reg_rdata = src_addr_q;
            OFS_DST_ADDR: reg_rdata = dst_addr_q;
            OFS_SRC_LEN:  reg_rdata = 32'(src_len_q);
            OFS_DST_LEN:  reg_rdata = 32'(dst_len_q);
            OFS_CFG:      reg_rdata = cfg_q;
            OFS_INT_STS:  reg_rdata = sts_q;
            OFS_INT_MASK: reg_rdata = mask_q;
            OFS_STATUS:   reg_rdata = stat_word;
            OFS_MISC:     reg_rdata = 32'(loop_q) << MISC_LOOP;
            default:      reg_rdata = '0;
        endcase
    end

    AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[FLG_OVF]) |-> $past(push && q_full)); // R8
endmodule

// File: rtl/dmaq_queue.sv
// In-order command queue. The head entry stays in place while the engine
// works on it and leaves only on pop. A push while full is ignored.
module dmaq_queue
    import dmaq_pkg::*;
#(
    parameter  int DEPTH  = 4,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  dma_cmd_t         push_cmd,
    input  logic             pop,
    output dma_cmd_t         head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    dma_cmd_t         slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slot[rd_ptr];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // One storage slot per queue entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin : p_slot
            if (!rst_n)                                slot[g] <= '0;
            else if (do_push && wr_ptr == PTR_W'(g))   slot[g] <= push_cmd;
        end
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin : p_ptrs
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R8
endmodule

// File: rtl/dmaq_mover.sv
// Step engine: loads the queue head, splits it into steps of at most
// BURST_WORDS, reads each word (and in loopback writes it back), then
// retires the command with done or error. Assumes read data is valid in
// the cycle the read request is accepted.
module dmaq_mover
    import dmaq_pkg::*;
#(
    parameter  int BURST_WORDS = 256,
    localparam int BW_W        = $clog2(BURST_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dma_cmd_t          head,
    input  logic              q_empty,
    input  logic              loop_en,
    output logic              pop,
    output logic              ev_done,
    output logic              ev_err,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_req_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              sink_valid,
    output logic [DATA_W-1:0] sink_data
);
    typedef enum logic [1:0] {S_IDLE, S_PLAN, S_READ, S_WRITE} state_t;

    state_t            state;
    logic [ADDR_W-1:0] src_a, dst_a;
    logic [LEN_W-1:0]  src_n, dst_n, step_w;
    logic [BW_W-1:0]   burst_n, beats_left;
    logic [DATA_W-1:0] data_q;
    logic              loop_act, both_zero, last_beat, rd_fire;

    // Step size for the next burst
    always_comb begin : p_step_size
        step_w = (src_n < LEN_W'(BURST_WORDS)) ? src_n : LEN_W'(BURST_WORDS);
        if (loop_en && dst_n < step_w) step_w = dst_n;
    end

    assign both_zero = (src_n == '0) && (dst_n == '0);
    assign ev_done   = (state == S_PLAN) && both_zero;
    assign ev_err    = (state == S_PLAN) && !both_zero && (step_w == '0);
    assign pop       = ev_done || ev_err;
    assign last_beat = (beats_left == BW_W'(1));
    assign rd_fire   = (state == S_READ) && mem_req_ready;

    assign mem_req_valid = (state == S_READ) || (state == S_WRITE);
    assign mem_req_write = (state == S_WRITE);
    assign mem_req_addr  = (state == S_WRITE) ? dst_a : src_a;
    assign mem_req_wdata = data_q;
    assign sink_valid    = rd_fire && !loop_act;
    assign sink_data     = mem_rdata;

    // Command sequencing and residual bookkeeping
    always_ff @(posedge clk) begin : p_engine
        if (!rst_n) begin
            state      <= S_IDLE;
            src_a      <= '0;
            dst_a      <= '0;
            src_n      <= '0;
            dst_n      <= '0;
            burst_n    <= '0;
            beats_left <= '0;
            data_q     <= '0;
            loop_act   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (!q_empty) begin
                    src_a <= head.src_addr;
                    dst_a <= head.dst_addr;
                    src_n <= head.src_words;
                    dst_n <= head.dst_words;
                    state <= S_PLAN;
                end
                S_PLAN: begin
                    loop_act <= loop_en;
                    if (pop) begin
                        state <= S_IDLE;
                    end else begin
                        burst_n    <= BW_W'(step_w);
                        beats_left <= BW_W'(step_w);
                        state      <= S_READ;
                    end
                end
                S_READ: if (mem_req_ready) begin
                    data_q <= mem_rdata;
                    src_a  <= src_a + ADDR_W'(4);
                    if (loop_act) begin
                        state <= S_WRITE;
                    end else begin
                        beats_left <= beats_left - 1'b1;
                        if (last_beat) begin
                            src_n <= src_n - LEN_W'(burst_n);
                            state <= S_PLAN;
                        end
                    end
                end
                S_WRITE: if (mem_req_ready) begin
                    dst_a      <= dst_a + ADDR_W'(4);
                    beats_left <= beats_left - 1'b1;
                    if (last_beat) begin
                        src_n <= src_n - LEN_W'(burst_n);
                        dst_n <= dst_n - LEN_W'(burst_n);
                        state <= S_PLAN;
                    end else begin
                        state <= S_READ;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata))); // R13
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00)); // R1
    AST_SINK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sink_valid |-> !mem_req_write); // R4
endmodule

// File: rtl/dmaq_top.sv
// Queued DMA engine top: register file, command queue and step engine.
// Assumes one register access per cycle and a single memory port.
module dmaq_top
    import dmaq_pkg::*;
#(
    parameter  int QUEUE_DEPTH = 4,
    parameter  int BURST_WORDS = 256,
    localparam int QCNT_W      = $clog2(QUEUE_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wen,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req_valid,
    output logic        mem_req_write,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_req_ready,
    input  logic [31:0] mem_rdata,
    output logic        sink_valid,
    output logic [31:0] sink_data,
    output logic        irq
);
    dma_cmd_t          push_cmd, head;
    logic              push, pop, q_full, q_empty, ev_done, ev_err, loop_en;
    logic [QCNT_W-1:0] q_count;

    dmaq_regs #(.QCNT_W(QCNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .push(push), .push_cmd(push_cmd),
        .q_full(q_full), .q_empty(q_empty), .q_count(q_count),
        .ev_done(ev_done), .ev_err(ev_err),
        .loop_en(loop_en), .irq(irq)
    );

    dmaq_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_cmd(push_cmd), .pop(pop),
        .head(head), .count(q_count), .full(q_full), .empty(q_empty)
    );

    dmaq_mover #(.BURST_WORDS(BURST_WORDS)) u_mover (
        .clk(clk), .rst_n(rst_n),
        .head(head), .q_empty(q_empty), .loop_en(loop_en),
        .pop(pop), .ev_done(ev_done), .ev_err(ev_err),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rdata(mem_rdata),
        .sink_valid(sink_valid), .sink_data(sink_data)
    );

    AST_BUSY_HAS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !q_empty); // R8
endmodule

// File: tb/test_dmaq_top.sv
// Self-checking bench: sweeps lengths, modes and queue occupancy against a
// behavioural memory whose contents are an arithmetic pattern.
module test_dmaq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid, mem_req_write, sink_valid, irq;
    logic [31:0] mem_req_addr, mem_req_wdata, mem_rdata, sink_data;
    logic        mem_ready = 1'b1;
    int          rdy_mode = 0;   // 0 always ready, 1 alternating, 2 stalled

    int n_cmp = 0, n_bad = 0, cycles = 0;
    int n_rd, n_wr, n_sink;
    logic [31:0] sink_sum;
    logic [31:0] rd_log [8];
    logic [31:0] mem [1024];

    dmaq_top i_dmaq_top (
        .clk(clk), .rst_n(rst_n),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_ready), .mem_rdata(mem_rdata),
        .sink_valid(sink_valid), .sink_data(sink_data), .irq(irq)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [31:0] pat(input int i);
        return 32'h5A00_0000 ^ (32'(i) * 32'h0001_0003);
    endfunction

    assign mem_rdata = mem[mem_req_addr[11:2]];

    // Memory model and traffic counters
    always @(posedge clk) begin
        if (mem_req_valid && mem_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr[11:2]] <= mem_req_wdata;
                n_wr = n_wr + 1;
            end else begin
                rd_log[n_rd % 8] = mem_req_addr;
                n_rd = n_rd + 1;
            end
        end
        if (sink_valid) begin
            n_sink   = n_sink + 1;
            sink_sum = sink_sum + sink_data;
        end
    end

    always @(negedge clk) begin
        case (rdy_mode)
            0:       mem_ready <= 1'b1;
            1:       mem_ready <= ~mem_ready;
            default: mem_ready <= 1'b0;
        endcase
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                finish_run();
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_counts();
        n_rd = 0; n_wr = 0; n_sink = 0; sink_sum = '0;
    endtask

    task automatic wait_empty();
        logic [31:0] v;
        for (int k = 0; k < 20000; k++) begin
            rd(8'h1C, v);
            if (v[30]) break;
        end
    endtask

    task automatic push(input int sa, input int da, input int sl, input int dl);
        wr(8'h00, 32'(sa));
        wr(8'h04, 32'(da));
        wr(8'h08, 32'(sl));
        wr(8'h0C, 32'(dl));
    endtask

    initial begin
        logic [31:0] v, exp_sum;
        int bad;
        for (int i = 0; i < 1024; i++) mem[i] = pat(i);
        clear_counts();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset values
        rd(8'h10, v); check("R12 cfg reset", v, 32'h50B);
        rd(8'h18, v); check("R12 mask reset", v, 32'hFFFF_FFFF);
        rd(8'h14, v); check("R12 flags reset", v, 32'h0);
        rd(8'h20, v); check("R12 misc reset", v, 32'h0);
        rd(8'h1C, v); check("R12 R9 status reset", v, 32'h4000_0000);
        check("R12 irq reset", 32'(irq), 32'h0);

        // R11 writable fields
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); check("R11 cfg ones", v, 32'hFFB);
        wr(8'h10, 32'h0);         rd(8'h10, v); check("R11 cfg zeros", v, 32'h00B);
        wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v); check("R11 misc ones", v, 32'h10);
        wr(8'h20, 32'h0);

        // R2 length width
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); check("R2 src len ro bits", v, 32'h07FF_FFFF);
        wr(8'h08, 32'h0);

        // R1 R4 R6 non-loopback sweep, unaligned source address
        for (int t = 0; t < 3; t++) begin
            int n = (t == 0) ? 1 : (t == 1) ? 3 : 8;
            clear_counts();
            push(32'h103, 0, n, 0);
            wait_empty();
            exp_sum = '0;
            for (int k = 0; k < n; k++) exp_sum = exp_sum + pat(64 + k);
            check("R4 reads", 32'(n_rd), 32'(n));
            check("R4 no writes", 32'(n_wr), 0);
            check("R1 first read addr", rd_log[0], 32'h100);
            check("R4 sink sum", sink_sum, exp_sum);
            rd(8'h14, v); check("R6 done flags", v, 32'h3000);
            check("R10 irq masked", 32'(irq), 0);
            wr(8'h14, 32'h3000); rd(8'h14, v); check("R10 w1c", v, 0);
        end

        // R3 R5 loopback sweep with alternating ready, incl. multi-burst
        wr(8'h20, 32'h10);
        rdy_mode = 1;
        for (int t = 0; t < 4; t++) begin
            int n = (t == 0) ? 1 : (t == 1) ? 5 : (t == 2) ? 17 : 300;
            for (int k = 0; k < 400; k++) mem[512 + k] = '0;
            clear_counts();
            push(0, 32'h802, n, n);
            wait_empty();
            bad = 0;
            for (int k = 0; k < n; k++) if (mem[512 + k] !== pat(k)) bad++;
            check("R5 reads", 32'(n_rd), 32'(n));
            check("R5 writes", 32'(n_wr), 32'(n));
            check("R5 copy mismatches", 32'(bad), 0);
            check("R5 sink idle", 32'(n_sink), 0);
            check("R5 beyond end untouched", mem[512 + n], 0);
            rd(8'h14, v); check("R3 R6 done", v, 32'h3000);
            wr(8'h14, 32'hFFFF_FFFF);
        end
        rdy_mode = 0;

        // R3 R7 loopback limited by destination, then error
        clear_counts();
        push(0, 32'h800, 10, 4);
        wait_empty();
        check("R3 limited reads", 32'(n_rd), 4);
        check("R3 limited writes", 32'(n_wr), 4);
        rd(8'h14, v); check("R7 error flag", v, 32'h8000);
        wr(8'h14, 32'hFFFF_FFFF);

        // R7 non-loopback with destination length left over
        wr(8'h20, 32'h0);
        clear_counts();
        push(0, 0, 3, 2);
        wait_empty();
        check("R7 reads before error", 32'(n_rd), 3);
        rd(8'h14, v); check("R7 error no done", v, 32'h8000);
        wr(8'h14, 32'hFFFF_FFFF);

        // R6 empty command
        clear_counts();
        push(0, 0, 0, 0);
        wait_empty();
        check("R6 zero cmd no access", 32'(n_rd + n_wr), 0);
        rd(8'h14, v); check("R6 zero cmd done", v, 32'h3000);

        // R10 mask and irq
        wr(8'h18, ~(32'h1 << 13));
        @(negedge clk); check("R10 irq unmasked", 32'(irq), 1);
        wr(8'h18, 32'hFFFF_FFFF);
        @(negedge clk); check("R10 irq remasked", 32'(irq), 0);
        wr(8'h14, 32'h1000); rd(8'h14, v); check("R10 partial w1c", v, 32'h2000);
        wr(8'h18, ~(32'h1 << 12));
        @(negedge clk); check("R10 irq other bit", 32'(irq), 0);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);

        // R8 R9 R13 queue fill and overflow with stalled memory
        rdy_mode = 2;
        @(negedge clk);
        clear_counts();
        for (int i = 0; i < 5; i++) push(32'h40 * i, 0, 1, 0);
        rd(8'h1C, v); check("R9 full count", v, 32'h8000_0004);
        rd(8'h14, v); check("R8 overflow flag", v, 32'h4000);
        check("R13 stalled req valid", 32'(mem_req_valid), 1);
        check("R13 stalled req addr", mem_req_addr, 32'h0);
        rdy_mode = 0;
        wait_empty();
        check("R8 dropped fifth", 32'(n_rd), 4);
        for (int i = 0; i < 4; i++) check("R8 order", rd_log[i], 32'(32'h40 * i));
        rd(8'h14, v); check("R8 flags after drain", v, 32'h7000);
        rd(8'h1C, v); check("R9 empty again", v, 32'h4000_0000);

        finish_run();
    end
endmodule